// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Inserter

This block sits in the transmit path of a DS1 framer. For each of 24 voice channels it keeps a four-bit signaling nibble (A, B, C, D). It then overwrites the least significant bit of that channel's byte in the signaling frames of the superframe. Channel bytes arrive with a channel index and a one-based frame index. The block supports both the 12-frame D4 superframe and the 24-frame ESF superframe. Its output is the modified byte, one cycle after the input.

Each channel's nibble can come from two sources. One is a serial control stream that refreshes the nibble continuously. The other is a processor register port. A per-channel hold flag, written through the processor port, stops the stream from changing that channel. The value the processor wrote is then kept and transmitted, which is how trunk conditioning is done.

Top module: `rbs_inserter`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid` was high and low otherwise. `out_byte` is registered and holds the result for the byte presented in the previous cycle.
- R2: Output bits 7..1 always equal input bits 7..1. When `sig_en` is low, the whole byte passes through unchanged.
- R3: In both modes with `sig_en` high, frame 6 takes signaling bit A and frame 12 takes signaling bit B into output bit 0. Nibble bit 3 is A and nibble bit 2 is B.
- R4: In ESF mode (`esf_mode`=1), frame 18 takes bit C (nibble bit 1) and frame 24 takes bit D (nibble bit 0) into output bit 0.
- R5: In D4 mode (`esf_mode`=0), C and D are never inserted. Every frame other than 6 and 12, including 18 and 24, passes unchanged. In ESF mode, frames other than 6, 12, 18 and 24 pass unchanged.
- R6: While a channel's hold flag is clear, a stream update (`st_valid`, `st_ch`, `st_sig`) replaces that channel's stored nibble.
- R7: While a channel's hold flag is set, stream updates to it are ignored. The nibble last written by the processor is held and inserted.
- R8: If a processor write and a stream update target the same channel in the same cycle, the processor wins when the hold flag was set before that cycle. Otherwise the stream wins. A processor write always sets the hold flag to `cpu_whold`.
- R9: `cpu_rdata` and `cpu_rhold` show the nibble and hold flag of `cpu_addr` one cycle after the address is presented. They reflect writes completed at earlier clock edges.
- R10: After reset, every nibble and every hold flag is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_en | input | 1 | Global signaling insertion enable |
| esf_mode | input | 1 | 1 = 24-frame ESF, 0 = 12-frame D4 |
| in_valid | input | 1 | Channel byte strobe |
| in_ch | input | 5 | Channel index 0..23 |
| in_frame | input | 5 | Frame number within superframe, one-based |
| in_byte | input | 8 | Channel byte |
| st_valid | input | 1 | Stream signaling update strobe |
| st_ch | input | 5 | Channel of stream update |
| st_sig | input | 4 | Stream nibble {A,B,C,D} |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | 5 | Processor channel address (read and write) |
| cpu_wdata | input | 4 | Processor nibble {A,B,C,D} |
| cpu_whold | input | 1 | Hold flag written with the nibble |
| cpu_rdata | output | 4 | Registered nibble read data |
| cpu_rhold | output | 1 | Registered hold flag read data |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Byte with signaling inserted |

## Verification
A processor write and a stream update can land on the same channel in the same cycle. The bench provokes this twice: once on a channel whose hold flag is clear, and once on a channel whose hold flag is already set, each time with different nibbles from the two sources. The result is judged by reading the channel back through the register port. It is also judged by sending that channel's frame-6, 12, 18 and 24 bytes and comparing output bit 0 against the winner the bench model expects.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    SLOT_A = 2'd0,
    SLOT_B = 2'd1,
    SLOT_C = 2'd2,
    SLOT_D = 2'd3
  } sig_slot_e;

  localparam int SIG_W = 4;

  // nibble layout: bit3 = A, bit2 = B, bit1 = C, bit0 = D
  function automatic logic pick_bit(input logic [SIG_W-1:0] nib, input sig_slot_e slot);
    logic b;
    case (slot)
      SLOT_A:  b = nib[3];
      SLOT_B:  b = nib[2];
      SLOT_C:  b = nib[1];
      default: b = nib[0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/rbs_slot_decode.sv
module rbs_slot_decode
  import rbs_pkg::*;
#(
  parameter int FR_W = 5
) (
  input  logic [FR_W-1:0] frame,
  input  logic            esf_mode,
  output logic            hit,
  output sig_slot_e       slot
);

  localparam logic [FR_W-1:0] FR_A = FR_W'(6);
  localparam logic [FR_W-1:0] FR_B = FR_W'(12);
  localparam logic [FR_W-1:0] FR_C = FR_W'(18);
  localparam logic [FR_W-1:0] FR_D = FR_W'(24);

  always_comb begin
    hit  = 1'b0;
    slot = SLOT_A;
    case (frame)
      FR_A: begin hit = 1'b1;     slot = SLOT_A; end
      FR_B: begin hit = 1'b1;     slot = SLOT_B; end
      FR_C: begin hit = esf_mode; slot = SLOT_C; end
      FR_D: begin hit = esf_mode; slot = SLOT_D; end
      default: ;
    endcase
  end

endmodule

// File: rtl/rbs_sig_store.sv
module rbs_sig_store
  import rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CH_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_valid,
  input  logic [CH_W-1:0]  st_ch,
  input  logic [SIG_W-1:0] st_sig,
  input  logic             cpu_wr,
  input  logic [CH_W-1:0]  cpu_addr,
  input  logic [SIG_W-1:0] cpu_wdata,
  input  logic             cpu_whold,
  input  logic [CH_W-1:0]  ins_ch,
  output logic [SIG_W-1:0] ins_sig,
  output logic [SIG_W-1:0] cpu_rdata,
  output logic             cpu_rhold
);

  logic [NUM_CH-1:0][SIG_W-1:0] sig_q;
  logic [NUM_CH-1:0]            hold_q;

  // one write arbiter per channel
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    logic st_hit, cpu_hit;
    assign st_hit  = st_valid && (st_ch == CH_W'(gi)) && !hold_q[gi];
    assign cpu_hit = cpu_wr && (cpu_addr == CH_W'(gi));

    always_ff @(posedge clk) begin
      if (rst) begin
        sig_q[gi]  <= '0;
        hold_q[gi] <= 1'b0;
      end else begin
        if (cpu_hit) hold_q[gi] <= cpu_whold;
        if (st_hit)       sig_q[gi] <= st_sig;
        else if (cpu_hit) sig_q[gi] <= cpu_wdata;
      end
    end
  end

  logic ins_ok, rd_ok;
  assign ins_ok  = (32'(ins_ch) < NUM_CH);
  assign rd_ok   = (32'(cpu_addr) < NUM_CH);
  assign ins_sig = ins_ok ? sig_q[ins_ch] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      cpu_rhold <= 1'b0;
    end else begin
      cpu_rdata <= rd_ok ? sig_q[cpu_addr] : '0;
      cpu_rhold <= rd_ok ? hold_q[cpu_addr] : 1'b0;
    end
  end

endmodule

// File: rtl/rbs_inserter.sv
module rbs_inserter
  import rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int FR_W   = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_en,
  input  logic              esf_mode,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_ch,
  input  logic [FR_W-1:0]   in_frame,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              st_valid,
  input  logic [CH_W-1:0]   st_ch,
  input  logic [SIG_W-1:0]  st_sig,
  input  logic              cpu_wr,
  input  logic [CH_W-1:0]   cpu_addr,
  input  logic [SIG_W-1:0]  cpu_wdata,
  input  logic              cpu_whold,
  output logic [SIG_W-1:0]  cpu_rdata,
  output logic              cpu_rhold,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte
);

  logic [SIG_W-1:0] ins_sig;
  logic             slot_hit;
  sig_slot_e        slot;

  rbs_sig_store #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_store (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_ch(st_ch), .st_sig(st_sig),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_whold(cpu_whold),
    .ins_ch(in_ch), .ins_sig(ins_sig),
    .cpu_rdata(cpu_rdata), .cpu_rhold(cpu_rhold)
  );

  rbs_slot_decode #(.FR_W(FR_W)) u_dec (
    .frame(in_frame), .esf_mode(esf_mode), .hit(slot_hit), .slot(slot)
  );

  logic lsb_nxt;
  assign lsb_nxt = (sig_en && slot_hit) ? pick_bit(ins_sig, slot) : in_byte[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_byte <= {in_byte[BYTE_W-1:1], lsb_nxt};
    end
  end

endmodule

// File: rtl/rbs_inserter_chk.sv
module rbs_inserter_chk #(
  parameter int FR_W   = 5,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sig_en,
  input logic              esf_mode,
  input logic              in_valid,
  input logic [FR_W-1:0]   in_frame,
  input logic [BYTE_W-1:0] in_byte,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_byte
);

  logic d4_cd;
  assign d4_cd = !esf_mode && (in_frame == FR_W'(18) || in_frame == FR_W'(24));

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_UPPER_BITS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_byte[BYTE_W-1:1] == $past(in_byte[BYTE_W-1:1])); // R2
  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sig_en) |=> out_byte == $past(in_byte)); // R2
  AST_D4_NO_CD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && d4_cd) |=> out_byte == $past(in_byte)); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid); // R10

endmodule

bind rbs_inserter rbs_inserter_chk #(.FR_W(FR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .sig_en(sig_en), .esf_mode(esf_mode),
  .in_valid(in_valid), .in_frame(in_frame), .in_byte(in_byte),
  .out_valid(out_valid), .out_byte(out_byte)
);

// File: tb/rbs_inserter_bench.sv
module rbs_inserter_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sig_en = 1'b0, esf_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] in_ch = '0, in_frame = '0;
  logic [7:0] in_byte = '0;
  logic       st_valid = 1'b0;
  logic [4:0] st_ch = '0;
  logic [3:0] st_sig = '0;
  logic       cpu_wr = 1'b0;
  logic [4:0] cpu_addr = '0;
  logic [3:0] cpu_wdata = '0;
  logic       cpu_whold = 1'b0;
  logic [3:0] cpu_rdata;
  logic       cpu_rhold;
  logic       out_valid;
  logic [7:0] out_byte;

  always #4 clk = ~clk;

  rbs_inserter u_rbs_inserter (
    .clk(clk), .rst(rst), .sig_en(sig_en), .esf_mode(esf_mode),
    .in_valid(in_valid), .in_ch(in_ch), .in_frame(in_frame), .in_byte(in_byte),
    .st_valid(st_valid), .st_ch(st_ch), .st_sig(st_sig),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_whold(cpu_whold),
    .cpu_rdata(cpu_rdata), .cpu_rhold(cpu_rhold),
    .out_valid(out_valid), .out_byte(out_byte)
  );

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_sig [24];
  logic       m_hold [24];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte(input logic [7:0] b, input int ch, input int fr);
    logic bit0;
    bit0 = b[0];
    if (sig_en) begin
      if (fr == 6)                  bit0 = m_sig[ch][3];
      else if (fr == 12)            bit0 = m_sig[ch][2];
      else if (esf_mode && fr == 18) bit0 = m_sig[ch][1];
      else if (esf_mode && fr == 24) bit0 = m_sig[ch][0];
    end
    return {b[7:1], bit0};
  endfunction

  // apply the strobes set up for this cycle, update the model, advance
  task automatic tick(input string tag);
    bit old_hold [24];
    for (int i = 0; i < 24; i++) old_hold[i] = m_hold[i];
    if (in_valid) begin
      exp_q.push_back(model_byte(in_byte, int'(in_ch), int'(in_frame)));
      tag_q.push_back(tag);
    end
    if (st_valid && !old_hold[st_ch]) m_sig[st_ch] = st_sig;
    if (cpu_wr) begin
      m_hold[cpu_addr] = cpu_whold;
      if (!(st_valid && st_ch == cpu_addr && !old_hold[cpu_addr])) m_sig[cpu_addr] = cpu_wdata;
    end
    @(negedge clk);
    in_valid = 1'b0; st_valid = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic send(input int ch, input int fr, input logic [7:0] b, input string tag);
    in_valid = 1'b1; in_ch = 5'(ch); in_frame = 5'(fr); in_byte = b;
    tick(tag);
  endtask

  task automatic stream(input int ch, input logic [3:0] s);
    st_valid = 1'b1; st_ch = 5'(ch); st_sig = s;
    tick("R6");
  endtask

  task automatic cpu_write(input int ch, input logic [3:0] d, input bit h);
    cpu_wr = 1'b1; cpu_addr = 5'(ch); cpu_wdata = d; cpu_whold = h;
    tick("R9");
  endtask

  task automatic cpu_read(input int ch, input string req);
    cpu_addr = 5'(ch);
    @(negedge clk);
    check(cpu_rdata == m_sig[ch], req, cpu_rdata, m_sig[ch]);
    check(cpu_rhold == m_hold[ch], req, cpu_rhold, m_hold[ch]);
  endtask

  task automatic sweep(input int ch, input string tag);
    send(ch, 6,  8'hA6, tag);
    send(ch, 12, 8'h5D, tag);
    send(ch, 18, 8'h3C, tag);
    send(ch, 24, 8'hC3, tag);
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R1", 1, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_byte == e, t, out_byte, e);
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      done = 1;
      check(1'b0, "watchdog", wd, 20000);
      report();
    end
  end

  initial begin
    for (int i = 0; i < 24; i++) begin m_sig[i] = '0; m_hold[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R10", out_valid, 0);
    cpu_read(0, "R10");
    cpu_read(23, "R10");

    // D4 mode
    sig_en = 1'b1; esf_mode = 1'b0;
    stream(3, 4'b1010);
    cpu_read(3, "R6");
    send(3, 6,  8'hFE, "R3");
    send(3, 12, 8'hFF, "R3");
    send(3, 3,  8'h81, "R5");
    send(3, 18, 8'h10, "R5");
    send(3, 24, 8'h11, "R5");
    stream(3, 4'b0101);
    sweep(3, "R5");

    // ESF mode
    esf_mode = 1'b1;
    stream(9, 4'b0110);
    sweep(9, "R4");
    send(9, 7, 8'h42, "R5");
    stream(9, 4'b1001);
    sweep(9, "R3");

    // global disable
    sig_en = 1'b0;
    sweep(9, "R2");
    sig_en = 1'b1;

    // hold / override
    cpu_write(5, 4'b0101, 1'b1);
    stream(5, 4'b1111);
    cpu_read(5, "R7");
    sweep(5, "R7");

    // same-cycle collision, hold clear: stream wins
    st_valid = 1'b1; st_ch = 5'd7; st_sig = 4'b1100;
    cpu_wr = 1'b1; cpu_addr = 5'd7; cpu_wdata = 4'b0011; cpu_whold = 1'b0;
    tick("R8");
    cpu_read(7, "R8");
    sweep(7, "R8");

    // same-cycle collision, hold set: processor wins
    st_valid = 1'b1; st_ch = 5'd5; st_sig = 4'b0110;
    cpu_wr = 1'b1; cpu_addr = 5'd5; cpu_wdata = 4'b1001; cpu_whold = 1'b1;
    tick("R8");
    cpu_read(5, "R8");
    sweep(5, "R8");

    // release hold, stream takes over again
    cpu_write(5, 4'b0000, 1'b0);
    stream(5, 4'b1110);
    cpu_read(5, "R6");
    sweep(5, "R6");

    // back-to-back bytes on different channels
    send(3, 6, 8'h00, "R1");
    send(9, 6, 8'h00, "R1");
    send(7, 24, 8'hFF, "R1");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      report();
    end
  end

endmodule